// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames as a byte stream and lays them out in a circular receive buffer in memory through a 32-bit word write port. Frame bytes, including the four FCS bytes, are packed little-endian into words starting four bytes past the current write offset. Once the last byte has arrived, a 4-byte header is written in front of the frame at the write offset. The header's low half is the receive status that comes with the last byte, and its high half is the byte count. The status is stored exactly as given: bit 0 ok, bit 1 alignment error, bit 2 CRC error, bit 3 oversize, bit 4 runt, bit 5 symbol error, bit 13 broadcast, bit 14 own-address match, bit 15 multicast. The write offset then advances to the next 4-byte boundary past the frame.

The host consumes frames and reports its position through a read-pointer register. By convention that register holds the consumed offset minus 16, and the block adds the 16 back. From the two offsets the block derives a buffer-empty flag and the free space. A frame that would run into unread data is dropped: its header is never written, the write offset stays put, an overflow interrupt bit is raised and a missed-frame counter counts it. A stored frame raises a receive-OK bit. Both interrupt bits are cleared by writing ones to them.

The input is a valid/ready stream. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle after a last byte, while the header is written, and is high at all other times. The source must hold its byte, last flag and status stable while `in_ready` is low. The memory port is a plain write strobe that the memory accepts in every cycle. The ring size select is static between resets; the value 3 behaves as 2.

Top module: `rxring_writer`

## Requirements
- R1: After reset, `wr_offset` is 0, `buf_empty` is 1, `irq_status` is 0, `missed_cnt` is 0 and `in_ready` is 1.
- R2: The ring holds 8192 << `ring_sel` bytes (0: 8K, 1: 16K, 2: 32K). Every memory address is taken modulo that size, so frame data that passes the ring end continues at offset 0.
- R3: Frame byte k goes to address `wr_offset`+4+k, in lane k mod 4 of a 32-bit word: bits 7:0 hold the lowest address. Every write is a whole word at a 4-aligned address, and the unused lanes of a frame's final word are written as 0.
- R4: The header is written at `wr_offset` in the cycle after the last byte is accepted, after all of the frame's data words. Bits 15:0 hold `in_status` sampled with the last byte, and bits 31:16 hold the number of bytes in the frame.
- R5: On a stored frame of L bytes, `wr_offset` becomes (`wr_offset` + L + 4) rounded up to a multiple of 4, modulo the ring size. This happens in the header cycle, and `in_ready` is low for that one cycle only.
- R6: The read offset is (`host_rdptr` + 16) modulo the ring size. `host_rdptr` resets to the value whose read offset is 0. `buf_empty` is 1 exactly when the read offset equals `wr_offset`.
- R7: Free space F is (read offset − `wr_offset`) modulo the ring size, or the full ring size when they are equal. A frame is stored only if its rounded size round4(L+4) is less than F. Otherwise no header is written, `wr_offset` is unchanged, and no data word is written whose relative offset r (from `wr_offset`) fails r+4 < F.
- R8: `irq_status` bit 0 is set when a frame is stored and bit 4 is set when a frame is dropped. Writing a 1 to a bit through `irq_clr` with `irq_clr_we` clears that bit. All other bits always read 0.
- R9: When a bit is set and cleared in the same cycle, the set wins.
- R10: `missed_cnt` increases by one for every dropped frame and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_sel | input | 2 | Ring size select, size = 8192 << value |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_status | input | 16 | Receive status, sampled with the last byte |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 15 | Byte address of the word, 4-aligned |
| mem_wdata | output | 32 | Word data, little-endian |
| host_rdptr_we | input | 1 | Host read-pointer write strobe |
| host_rdptr | input | 15 | Host read pointer (consumed offset − 16) |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr | input | 16 | Write-1-to-clear mask |
| irq_status | output | 16 | Interrupt status, bit 0 stored, bit 4 dropped |
| buf_empty | output | 1 | Read offset equals write offset |
| wr_offset | output | 15 | Current hardware write offset |
| missed_cnt | output | 24 | Dropped-frame count |

## Verification
A frame commit can land in the same cycle as a host clear of the receive-OK bit. The bench provokes this by first leaving bit 0 set from an earlier frame. It then drives an `irq_clr` of bit 0 exactly in the cycle after the next frame's last byte, which is the header cycle. The bit must read 1 afterwards; a clear that won would leave it at 0. The drop boundary is also placed exactly: one frame's rounded size equals the free space and must be dropped, and the next is four bytes smaller and must be stored.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int unsigned HDR_BYTES  = 4;
  localparam int unsigned HDR_LEN_W  = 16;
  localparam int unsigned STAT_W     = 16;
  localparam int unsigned IRQ_W      = 16;
  localparam int unsigned IRQ_STORED = 0;
  localparam int unsigned IRQ_DROPPED = 4;

  typedef enum logic [0:0] {
    ST_DATA = 1'b0,
    ST_HDR  = 1'b1
  } wr_state_e;
endpackage

// File: rtl/rxr_ring_math.sv
module rxr_ring_math #(
  parameter int unsigned BASE_BYTES = 8192,
  parameter int unsigned SEL_MAX    = 2,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned RD_BIAS    = 16
) (
  input  logic [1:0]        ring_sel,
  input  logic [ADDR_W-1:0] rdptr_raw,
  input  logic [ADDR_W-1:0] wr_offset,
  output logic [ADDR_W-1:0] mask,
  output logic [ADDR_W:0]   avail,
  output logic              empty
);
  logic [1:0]        sel_c;
  logic [ADDR_W:0]   size;
  logic [ADDR_W-1:0] rd_offset;
  logic [ADDR_W-1:0] gap;

  always_comb begin
    sel_c     = (ring_sel > 2'(SEL_MAX)) ? 2'(SEL_MAX) : ring_sel;
    size      = (ADDR_W+1)'(BASE_BYTES) << sel_c;
    mask      = ADDR_W'(size - 1'b1);
    rd_offset = (rdptr_raw + ADDR_W'(RD_BIAS)) & mask;
    gap       = (rd_offset - wr_offset) & mask;
    avail     = (gap == '0) ? size : {1'b0, gap};
    empty     = (rd_offset == wr_offset);
  end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxring_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [STAT_W-1:0] in_status,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W:0]   avail,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [ADDR_W-1:0] wr_offset,
  output logic              frame_ok,
  output logic              frame_drop
);
  localparam int unsigned REL_W = HDR_LEN_W + 2;

  wr_state_e          state;
  logic [31:0]        wbuf;
  logic [31:0]        wbuf_n;
  logic [1:0]         lane;
  logic [REL_W-1:0]   rel;
  logic [HDR_LEN_W-1:0] len;
  logic               drop;
  logic [STAT_W-1:0]  stat_q;
  logic               accept;
  logic               word_done;
  logic               room;
  logic               in_hdr;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign wbuf_n[8*l +: 8] = (lane == 2'(l)) ? in_data : wbuf[8*l +: 8];
  end

  always_comb begin
    in_ready   = (state == ST_DATA);
    accept     = in_valid && in_ready;
    word_done  = accept && ((lane == 2'd3) || in_last);
    room       = (rel + REL_W'(HDR_BYTES)) < REL_W'(avail);
    in_hdr     = (state == ST_HDR);
    frame_ok   = in_hdr && !drop;
    frame_drop = in_hdr && drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_DATA;
      wbuf      <= '0;
      lane      <= '0;
      rel       <= REL_W'(HDR_BYTES);
      len       <= '0;
      drop      <= 1'b0;
      stat_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wr_offset <= '0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        len <= len + 1'b1;
        if (word_done) begin
          if (room && !drop) begin
            mem_we    <= 1'b1;
            mem_addr  <= (wr_offset + rel[ADDR_W-1:0]) & mask;
            mem_wdata <= wbuf_n;
          end else begin
            drop <= 1'b1;
          end
          rel  <= rel + REL_W'(HDR_BYTES);
          wbuf <= '0;
          lane <= '0;
        end else begin
          wbuf <= wbuf_n;
          lane <= lane + 1'b1;
        end
        if (in_last) begin
          state  <= ST_HDR;
          stat_q <= in_status;
        end
      end else if (in_hdr) begin
        if (!drop) begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_offset;
          mem_wdata <= {len, stat_q};
          wr_offset <= (wr_offset + rel[ADDR_W-1:0]) & mask;
        end
        state <= ST_DATA;
        rel   <= REL_W'(HDR_BYTES);
        len   <= '0;
        drop  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq
  import rxring_pkg::*;
#(
  parameter int unsigned MISS_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic              frame_drop,
  input  logic              irq_clr_we,
  input  logic [IRQ_W-1:0]  irq_clr,
  output logic [IRQ_W-1:0]  irq_status,
  output logic [MISS_W-1:0] missed_cnt
);
  localparam logic [IRQ_W-1:0] IMPL =
    (IRQ_W'(1) << IRQ_STORED) | (IRQ_W'(1) << IRQ_DROPPED);

  logic [IRQ_W-1:0] set_v;
  logic [IRQ_W-1:0] clr_v;

  always_comb begin
    set_v = (IRQ_W'(frame_ok) << IRQ_STORED) | (IRQ_W'(frame_drop) << IRQ_DROPPED);
    clr_v = irq_clr_we ? irq_clr : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_status <= '0;
      missed_cnt <= '0;
    end else begin
      irq_status <= ((irq_status & ~clr_v) | set_v) & IMPL;
      if (frame_drop) missed_cnt <= missed_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int unsigned BASE_BYTES = 8192,
  parameter int unsigned SEL_MAX    = 2,
  parameter int unsigned RD_BIAS    = 16,
  parameter int unsigned MISS_W     = 24,
  localparam int unsigned ADDR_W    = $clog2(BASE_BYTES) + SEL_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ring_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [15:0]       in_status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              host_rdptr_we,
  input  logic [ADDR_W-1:0] host_rdptr,
  input  logic              irq_clr_we,
  input  logic [15:0]       irq_clr,
  output logic [15:0]       irq_status,
  output logic              buf_empty,
  output logic [ADDR_W-1:0] wr_offset,
  output logic [MISS_W-1:0] missed_cnt
);
  logic [ADDR_W-1:0] rdptr_q;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W:0]   avail;
  logic              frame_ok;
  logic              frame_drop;

  always_ff @(posedge clk) begin
    if (!rst_n)             rdptr_q <= {ADDR_W{1'b0}} - ADDR_W'(RD_BIAS);
    else if (host_rdptr_we) rdptr_q <= host_rdptr;
  end

  rxr_ring_math #(
    .BASE_BYTES(BASE_BYTES), .SEL_MAX(SEL_MAX), .ADDR_W(ADDR_W), .RD_BIAS(RD_BIAS)
  ) u_math (
    .ring_sel (ring_sel),
    .rdptr_raw(rdptr_q),
    .wr_offset(wr_offset),
    .mask     (mask),
    .avail    (avail),
    .empty    (buf_empty)
  );

  rxr_packer #(.ADDR_W(ADDR_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_status (in_status),
    .mask      (mask),
    .avail     (avail),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr_offset (wr_offset),
    .frame_ok  (frame_ok),
    .frame_drop(frame_drop)
  );

  rxr_irq #(.MISS_W(MISS_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_ok  (frame_ok),
    .frame_drop(frame_drop),
    .irq_clr_we(irq_clr_we),
    .irq_clr   (irq_clr),
    .irq_status(irq_status),
    .missed_cnt(missed_cnt)
  );
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned MISS_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] wr_offset,
  input logic [15:0]       irq_status,
  input logic [MISS_W-1:0] missed_cnt
);
  // R5
  hdr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R5
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00));

  // R4
  hdr_at_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_offset != $past(wr_offset)) |-> (mem_we && mem_addr == $past(wr_offset)));

  // R8
  irq_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~16'h0011) == 16'h0000);

  // R10
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> irq_status[4]);

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> (wr_offset == $past(wr_offset)));
endmodule

bind rxring_writer rxring_writer_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .wr_offset (wr_offset),
  .irq_status(irq_status),
  .missed_cnt(missed_cnt)
);

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;
  localparam int AW = 15;
  localparam int MW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ring_sel = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_last = 1'b0;
  logic [15:0]   in_status = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          host_rdptr_we = 1'b0;
  logic [AW-1:0] host_rdptr = '0;
  logic          irq_clr_we = 1'b0;
  logic [15:0]   irq_clr = '0;
  logic [15:0]   irq_status;
  logic          buf_empty;
  logic [AW-1:0] wr_offset;
  logic [MW-1:0] missed_cnt;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
  } wr_t;

  wr_t exp_q[$];
  int  n_chk = 0;
  int  n_fail = 0;
  int  m_cur, m_rd, m_size, m_miss;

  rxring_writer u_rxring_writer (
    .clk(clk), .rst_n(rst_n), .ring_sel(ring_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_status(in_status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .host_rdptr_we(host_rdptr_we), .host_rdptr(host_rdptr),
    .irq_clr_we(irq_clr_we), .irq_clr(irq_clr), .irq_status(irq_status),
    .buf_empty(buf_empty), .wr_offset(wr_offset), .missed_cnt(missed_cnt)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write is compared against the queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected memory write", {mem_addr, mem_wdata}, 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a && mem_wdata == e.d, "R3,R4", "memory write",
              {mem_addr, mem_wdata}, {e.a, e.d});
      end
    end
  end

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    ring_sel = sel;
    in_valid = 1'b0;
    in_last = 1'b0;
    host_rdptr_we = 1'b0;
    irq_clr_we = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cur = 0;
    m_rd = 0;
    m_size = 8192 << sel;
    m_miss = 0;
  endtask

  task automatic set_rd(input int consumed);
    @(negedge clk);
    host_rdptr_we = 1'b1;
    host_rdptr = AW'(consumed - 16);
    m_rd = consumed & (m_size - 1);
    @(negedge clk);
    host_rdptr_we = 1'b0;
  endtask

  // driver: pushes the expected writes, then streams the bytes
  task automatic send_frame(input int len, input logic [15:0] st,
                            input int seed, input bit clr_in_hdr);
    int avail;
    int nw;
    int total;
    avail = (m_rd - m_cur) & (m_size - 1);
    if (avail == 0) avail = m_size;
    nw = (len + 3) / 4;
    total = 4 + 4 * nw;
    for (int w = 0; w < nw; w++) begin
      wr_t e;
      int r;
      r = 4 + 4 * w;
      e.d = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < len) e.d[8*b +: 8] = byte_of(seed, 4 * w + b);
      e.a = AW'((m_cur + r) & (m_size - 1));
      if (r + 4 < avail) exp_q.push_back(e);
    end
    if (total < avail) begin
      wr_t h;
      h.a = AW'(m_cur);
      h.d = {16'(len), st};
      exp_q.push_back(h);
      m_cur = (m_cur + total) & (m_size - 1);
    end else begin
      m_miss++;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data = byte_of(seed, i);
      in_last = (i == len - 1);
      in_status = st;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    if (clr_in_hdr) begin
      irq_clr_we = 1'b1;
      irq_clr = 16'h0001;
    end
    @(negedge clk);
    irq_clr_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset(2'd0);
    @(negedge clk);
    check(wr_offset == 0, "R1", "wr_offset after reset", wr_offset, 0);
    check(buf_empty == 1'b1, "R1", "buf_empty after reset", buf_empty, 1);
    check(irq_status == 0, "R1", "irq_status after reset", irq_status, 0);
    check(missed_cnt == 0, "R1", "missed_cnt after reset", missed_cnt, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R5 aligned frame and odd frame, R3 zero padding
    send_frame(60, 16'h4001, 1, 1'b0);
    check(wr_offset == 64, "R5", "offset after 60-byte frame", wr_offset, 64);
    check(buf_empty == 1'b0, "R6", "not empty after store", buf_empty, 0);
    check(irq_status == 16'h0001, "R8", "stored bit set", irq_status, 1);
    send_frame(61, 16'h2001, 9, 1'b0);
    check(wr_offset == 132, "R5", "offset after 61-byte frame", wr_offset, 132);

    // R8 write-1-to-clear
    @(negedge clk);
    irq_clr_we = 1'b1;
    irq_clr = 16'hFFFF;
    @(negedge clk);
    irq_clr_we = 1'b0;
    check(irq_status == 0, "R8", "clear by writing ones", irq_status, 0);

    // R6 read pointer bias
    set_rd(132);
    check(buf_empty == 1'b1, "R6", "empty when fully consumed", buf_empty, 1);
    set_rd(64);
    check(buf_empty == 1'b0, "R6", "not empty when partly consumed", buf_empty, 0);

    // R7 overflow policy on an 8K ring with the host idle
    do_reset(2'd0);
    for (int f = 0; f < 5; f++) send_frame(1500, 16'h0001, 20 + f, 1'b0);
    check(wr_offset == 7520, "R5", "offset after five frames", wr_offset, 7520);
    send_frame(1500, 16'h0001, 40, 1'b0);
    check(wr_offset == 7520, "R7", "offset held on drop", wr_offset, 7520);
    check(missed_cnt == 1, "R10", "missed count after drop", missed_cnt, 1);
    check(irq_status[4] == 1'b1, "R8", "dropped bit set", irq_status[4], 1);
    send_frame(60, 16'h0001, 41, 1'b0);
    check(wr_offset == 7584, "R7", "small frame still stored", wr_offset, 7584);
    send_frame(604, 16'h0001, 42, 1'b0);
    check(missed_cnt == 2, "R7", "frame equal to free space dropped", missed_cnt, 2);
    check(wr_offset == 7584, "R7", "offset held on boundary drop", wr_offset, 7584);
    send_frame(600, 16'h0001, 43, 1'b0);
    check(wr_offset == 8188, "R7", "frame just below free space stored", wr_offset, 8188);
    check(missed_cnt == 2, "R10", "count unchanged on store", missed_cnt, 2);

    // R2 wrap at the ring end, R9 set beats clear in the header cycle
    set_rd(8188);
    check(buf_empty == 1'b1, "R6", "empty before wrap frame", buf_empty, 1);
    check(irq_status[0] == 1'b1, "R9", "stored bit set before race", irq_status[0], 1);
    send_frame(60, 16'h8001, 50, 1'b1);
    check(irq_status[0] == 1'b1, "R9", "set wins over same-cycle clear", irq_status[0], 1);
    check(wr_offset == 60, "R2", "offset wrapped past 8K end", wr_offset, 60);

    // R2 16K ring: addresses pass 8192 without wrapping
    do_reset(2'd1);
    for (int f = 0; f < 6; f++) begin
      send_frame(1500, 16'h0001, 60 + f, 1'b0);
      set_rd(m_cur);
    end
    check(wr_offset == 9024, "R2", "offset on 16K ring", wr_offset, 9024);
    check(missed_cnt == 0, "R10", "no drops with host keeping up", missed_cnt, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all expected writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule